// File: doc/BRIEF.md
# Vertical Eight-Tap Image Filter

This block filters a raster video stream in the vertical direction. It keeps seven line delays on chip, so every time a pixel enters, the pixels at the same horizontal position on the seven previous lines are also available. The current pixel and those seven form an 8-tap window. Each tap is multiplied by a coefficient, and the eight products are summed into a full-precision result. Rounding and limiting of that result are left to the logic downstream.

The coefficients sit in a bank of stored sets. A set index arrives with each pixel, so the active set can change from one pixel to the next. The line length is a run-time input, limited to the range from 4 to `MAX_LEN`. A deployment that handles lines of up to 3076 samples sets `MAX_LEN` to 3076. Interleaved streams need no extra logic: the interleaved samples of one line are treated as a single longer line. An enable input stalls the whole datapath without losing what the line delays hold.

Top module: `vtf_top`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `acc_out` is 0 and `acc_valid` is 0.
- R2: The effective line length L is `line_len` limited to the range [4, `MAX_LEN`]. A value below 4 gives 4, and a value above `MAX_LEN` gives `MAX_LEN`. The shared line pointer wraps at L.
- R3: For accepted sample n, `acc_out` is the signed sum over taps t = 0..7 of `pix(n - t*L) * coef(set(n), t)`. Tap 0 is the current pixel. The sum is exact in `ACC_W` = 27 bits, including the extremes of -2048 and 2047 on every pixel and coefficient.
- R4: The set used for a sample is `set_sel` in the same cycle as that sample's pixel. When `cw_en` is high at a clock edge, `cw_data` is stored as coefficient `cw_tap` of set `cw_set`. The stored value applies to samples accepted at later edges.
- R5: A sample is accepted at an edge where `en` is high and the length is unchanged. The result for sample n appears after the second accepted edge that follows it. `acc_valid` is high exactly when n >= 7*L, counting n from 0 at reset or at the last length change.
- R6: At an edge where `en` is low, nothing advances: the pixel is ignored, and `acc_out`, `acc_valid`, the pointer and the line contents stay as they are.
- R7: At an edge where the effective length differs from the stored one, the new length is adopted, the pointer and the fill count return to zero, `acc_valid` drops, and the pixel presented in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Sample enable; low stalls the datapath |
| pix_in | input | DATA_W (12) | Signed pixel |
| set_sel | input | SET_W (8) | Coefficient set index for this pixel |
| line_len | input | LEN_W | Requested line length in samples |
| cw_en | input | 1 | Coefficient write strobe |
| cw_set | input | SET_W (8) | Set index for the write |
| cw_tap | input | TAP_W (3) | Tap index for the write |
| cw_data | input | COEF_W (12) | Signed coefficient value to store |
| acc_out | output | ACC_W (27) | Signed tap sum |
| acc_valid | output | 1 | All eight taps of `acc_out` hold real data |

## Verification
The bench builds the block with `MAX_LEN` = 16 and the default 256 sets of 8 taps. With that length, a full seven-line fill takes at most 112 samples, so the bench can fill the window several times and can also request lengths above the maximum to exercise the upper limit. Lengths of 4, 5 and 7 cover the lower limit and a line length that is not a power of two. The full set range is loaded with random values, so per-pixel set switching reaches every stored set. Extreme-valued sets drive the sum to its largest magnitudes.

// File: rtl/vtf_pkg.sv
package vtf_pkg;
   localparam int unsigned MIN_LINE = 4;

   function automatic int unsigned clamp_len(input int unsigned req,
                                             input int unsigned hi);
      if (req < MIN_LINE) return MIN_LINE;
      if (req > hi)       return hi;
      return req;
   endfunction
endpackage

// File: rtl/vtf_line_delay.sv
module vtf_line_delay #(
   parameter int DATA_W = 12,
   parameter int DEPTH  = 16,
   parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  ptr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] mem [DEPTH];

   // read the old value at ptr, then overwrite it: one line of delay
   assign dout = mem[ptr];

   always_ff @(posedge clk) begin
      if (wr_en) mem[ptr] <= din;
   end
endmodule

// File: rtl/vtf_coef_bank.sv
module vtf_coef_bank #(
   parameter int COEF_W = 12,
   parameter int TAPS   = 8,
   parameter int SETS   = 256,
   localparam int SET_W = $clog2(SETS),
   localparam int TAP_W = $clog2(TAPS)
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [SET_W-1:0]         wr_set,
   input  logic [TAP_W-1:0]         wr_tap,
   input  logic [COEF_W-1:0]        wr_data,
   input  logic [SET_W-1:0]         rd_set,
   output logic [TAPS*COEF_W-1:0]   rd_coefs
);
   logic [COEF_W-1:0] mem [SETS][TAPS];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_set][wr_tap] <= wr_data;
   end

   for (genvar t = 0; t < TAPS; t++) begin : g_rd
      assign rd_coefs[t*COEF_W +: COEF_W] = mem[rd_set][t];
   end
endmodule

// File: rtl/vtf_tap_sum.sv
module vtf_tap_sum #(
   parameter int DATA_W = 12,
   parameter int COEF_W = 12,
   parameter int TAPS   = 8,
   parameter int ACC_W  = 27
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    step,
   input  logic                    clr,
   input  logic                    in_valid,
   input  logic [TAPS*DATA_W-1:0]  in_taps,
   input  logic [TAPS*COEF_W-1:0]  in_coefs,
   output logic signed [ACC_W-1:0] acc,
   output logic                    acc_valid
);
   logic [TAPS*DATA_W-1:0]  taps_q;
   logic [TAPS*COEF_W-1:0]  coefs_q;
   logic                    v_q;
   logic signed [ACC_W-1:0] sum, d_ext, c_ext;

   always_comb begin
      sum   = '0;
      d_ext = '0;
      c_ext = '0;
      for (int t = 0; t < TAPS; t++) begin
         d_ext = ACC_W'($signed(taps_q[t*DATA_W +: DATA_W]));
         c_ext = ACC_W'($signed(coefs_q[t*COEF_W +: COEF_W]));
         sum   = sum + d_ext * c_ext;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         taps_q    <= '0;
         coefs_q   <= '0;
         v_q       <= 1'b0;
         acc       <= '0;
         acc_valid <= 1'b0;
      end else if (clr) begin
         v_q       <= 1'b0;
         acc_valid <= 1'b0;
      end else if (step) begin
         taps_q    <= in_taps;
         coefs_q   <= in_coefs;
         v_q       <= in_valid;
         acc       <= sum;
         acc_valid <= v_q;
      end
   end

   // R3: a valid output can only follow an accepted valid sample
   p_valid_needs_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(acc_valid) |-> $past(step) && !$past(clr));
endmodule

// File: rtl/vtf_top.sv
module vtf_top #(
   parameter int DATA_W  = 12,
   parameter int COEF_W  = 12,
   parameter int TAPS    = 8,
   parameter int SETS    = 256,
   parameter int MAX_LEN = 256,
   localparam int SET_W  = $clog2(SETS),
   localparam int TAP_W  = $clog2(TAPS),
   localparam int LEN_W  = $clog2(MAX_LEN + 1),
   localparam int PTR_W  = $clog2(MAX_LEN),
   localparam int ACC_W  = DATA_W + COEF_W + $clog2(TAPS),
   localparam int LINES  = TAPS - 1,
   localparam int CNT_W  = $clog2(TAPS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic [DATA_W-1:0]       pix_in,
   input  logic [SET_W-1:0]        set_sel,
   input  logic [LEN_W-1:0]        line_len,
   input  logic                    cw_en,
   input  logic [SET_W-1:0]        cw_set,
   input  logic [TAP_W-1:0]        cw_tap,
   input  logic [COEF_W-1:0]       cw_data,
   output logic signed [ACC_W-1:0] acc_out,
   output logic                    acc_valid
);
   import vtf_pkg::*;

   if (MAX_LEN < int'(MIN_LINE)) begin : g_bad_len
      $error("MAX_LEN must be at least 4");
   end
   if (TAPS < 2 || (TAPS & (TAPS - 1)) != 0) begin : g_bad_taps
      $error("TAPS must be a power of two of at least 2");
   end
   if ((SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two");
   end

   logic [LEN_W-1:0] len_eff, len_q;
   logic [PTR_W-1:0] ptr;
   logic [CNT_W-1:0] lines_done;
   logic             chg, step, full;

   assign len_eff = LEN_W'(clamp_len(int'(line_len), MAX_LEN));
   assign chg     = (len_eff != len_q);
   assign step    = en && !chg;
   assign full    = (lines_done == CNT_W'(LINES));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q      <= LEN_W'(MAX_LEN);
         ptr        <= '0;
         lines_done <= '0;
      end else if (chg) begin
         len_q      <= len_eff;
         ptr        <= '0;
         lines_done <= '0;
      end else if (en) begin
         if (LEN_W'(ptr) == len_q - 1'b1) begin
            ptr <= '0;
            if (!full) lines_done <= lines_done + 1'b1;
         end else begin
            ptr <= ptr + 1'b1;
         end
      end
   end

   // cascade of line delays; tap k sees the pixel from k lines earlier
   logic [DATA_W-1:0]      line_out [LINES];
   logic [TAPS*DATA_W-1:0] taps_flat;

   assign taps_flat[0 +: DATA_W] = pix_in;

   for (genvar k = 0; k < LINES; k++) begin : g_line
      logic [DATA_W-1:0] din_k;
      if (k == 0) begin : g_first
         assign din_k = pix_in;
      end else begin : g_next
         assign din_k = line_out[k-1];
      end
      vtf_line_delay #(.DATA_W(DATA_W), .DEPTH(MAX_LEN), .PTR_W(PTR_W)) u_dly (
         .clk   (clk),
         .wr_en (step),
         .ptr   (ptr),
         .din   (din_k),
         .dout  (line_out[k])
      );
      assign taps_flat[(k+1)*DATA_W +: DATA_W] = line_out[k];
   end

   logic [TAPS*COEF_W-1:0] coefs_flat;

   vtf_coef_bank #(.COEF_W(COEF_W), .TAPS(TAPS), .SETS(SETS)) u_coef (
      .clk      (clk),
      .wr_en    (cw_en),
      .wr_set   (cw_set),
      .wr_tap   (cw_tap),
      .wr_data  (cw_data),
      .rd_set   (set_sel),
      .rd_coefs (coefs_flat)
   );

   vtf_tap_sum #(.DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS), .ACC_W(ACC_W)) u_sum (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .clr       (chg),
      .in_valid  (full),
      .in_taps   (taps_flat),
      .in_coefs  (coefs_flat),
      .acc       (acc_out),
      .acc_valid (acc_valid)
   );

   // R2: stored length stays in range and the pointer stays below it
   p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      len_q >= LEN_W'(MIN_LINE) && len_q <= LEN_W'(MAX_LEN));
   p_ptr_below_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      LEN_W'(ptr) < len_q);
   // R5: a valid output implies the seven-line fill is complete
   p_valid_after_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> full);
   // R6: a stall edge changes nothing visible
   p_pause_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !chg) |=> $stable(ptr) && $stable(acc_out) && $stable(acc_valid));
   // R7: a length change restarts the pointer and drops validity
   p_len_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> ptr == '0 && lines_done == '0 && !acc_valid);
endmodule

// File: tb/vtf_top_test.sv
module vtf_top_test;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 12, CW = 12, TAPS = 8, SETS = 256, MAX_LEN = 16;
   localparam int SET_W = 8, TAP_W = 3, LEN_W = 5, ACC_W = 27;

   logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, cw_en = 1'b0;
   logic [DW-1:0] pix_in = '0;
   logic [SET_W-1:0] set_sel = '0, cw_set = '0;
   logic [LEN_W-1:0] line_len = LEN_W'(MAX_LEN);
   logic [TAP_W-1:0] cw_tap = '0;
   logic [CW-1:0] cw_data = '0;
   logic signed [ACC_W-1:0] acc_out;
   logic acc_valid;

   vtf_top #(.DATA_W(DW), .COEF_W(CW), .TAPS(TAPS), .SETS(SETS), .MAX_LEN(MAX_LEN)) uut (
      .clk(clk), .rst_n(rst_n), .en(en), .pix_in(pix_in), .set_sel(set_sel),
      .line_len(line_len), .cw_en(cw_en), .cw_set(cw_set), .cw_tap(cw_tap),
      .cw_data(cw_data), .acc_out(acc_out), .acc_valid(acc_valid));

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0;
   int cm [SETS][TAPS];
   int pix_h [0:4095];
   int set_h [0:4095];
   int L = MAX_LEN, nsamp = 0;
   int seed = 20240611;

   function automatic int clampl(int v);
      if (v < 4) return 4;
      if (v > MAX_LEN) return MAX_LEN;
      return v;
   endfunction

   function automatic longint expect_sum(int n);
      longint s = 0;
      for (int t = 0; t < TAPS; t++)
         s += longint'(cm[set_h[n]][t]) * longint'(pix_h[n - t*L]);
      return s;
   endfunction

   function automatic int sx12(int v);
      return (v & 32'h800) != 0 ? (v | 32'hFFFF_F000) : (v & 32'hFFF);
   endfunction

   task automatic check(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_coef(int s, int t, int v);
      cw_en = 1'b1; cw_set = SET_W'(s); cw_tap = TAP_W'(t); cw_data = CW'(v);
      cm[s][t] = sx12(v);
      @(posedge clk); @(negedge clk);
      cw_en = 1'b0;
   endtask

   // one cycle; inputs are applied at the negedge, results sampled at the next negedge
   task automatic cycle(bit e, int p, int s);
      longint prev_out = longint'(acc_out);
      bit prev_v = acc_valid;
      en = e; pix_in = DW'(p); set_sel = SET_W'(s);
      @(posedge clk);
      @(negedge clk);
      if (e) begin
         pix_h[nsamp] = sx12(p); set_h[nsamp] = s; nsamp++;
         if (nsamp >= 2) begin
            bit ev = (nsamp - 2) >= 7*L;
            check("R5 valid", longint'(acc_valid), longint'(ev));
            if (ev && acc_valid) check("R3/R4 sum", longint'(acc_out), expect_sum(nsamp - 2));
         end else begin
            check("R5 not yet valid", longint'(acc_valid), 0);
         end
      end else begin
         check("R6 out held", longint'(acc_out), prev_out);
         check("R6 valid held", longint'(acc_valid), longint'(prev_v));
      end
   endtask

   task automatic set_len(int v);
      line_len = LEN_W'(v); en = 1'b1;
      pix_in = DW'($urandom(seed)); seed = seed + 1;
      @(posedge clk); @(negedge clk);
      L = clampl(v); nsamp = 0;
      check("R7 valid dropped", longint'(acc_valid), 0);
   endtask

   task automatic run(int n, int pause_pct, int set_lo, int set_hi, bit rnd_pix, int fixed_pix);
      for (int i = 0; i < n; i++) begin
         bit e = ($urandom() % 100) >= pause_pct;
         int p = rnd_pix ? int'($urandom() & 32'hFFF) : fixed_pix;
         int s = set_lo + int'($urandom() % (set_hi - set_lo + 1));
         cycle(e, p, s);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      check("R1 reset out", longint'(acc_out), 0);
      check("R1 reset valid", longint'(acc_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release out", longint'(acc_out), 0);
      check("R1 after release valid", longint'(acc_valid), 0);

      for (int s = 0; s < SETS; s++)
         for (int t = 0; t < TAPS; t++)
            write_coef(s, t, int'($urandom() & 32'hFFF));

      // R2 shortest line, R5 fill, R6 random stalls
      set_len(4);
      run(80, 10, 0, SETS-1, 1, 0);
      // R2 odd length, R4 per-pixel set switching
      set_len(7);
      run(110, 15, 0, SETS-1, 1, 0);
      // R2 lower clamp: request 2, expect 4 (differs from 7, so R7 applies)
      set_len(2);
      run(60, 5, 0, SETS-1, 1, 0);
      // R2 upper clamp: request 31, expect MAX_LEN
      set_len(31);
      run(170, 10, 0, SETS-1, 1, 0);
      // R4 rewrite of one set while stalled, then use it
      en = 1'b0;
      for (int t = 0; t < TAPS; t++) write_coef(9, t, (t * 301) & 32'hFFF);
      run(40, 0, 9, 9, 1, 0);
      // R3 extremes: largest positive and most negative sums
      for (int t = 0; t < TAPS; t++) write_coef(3, t, 32'h800);
      for (int t = 0; t < TAPS; t++) write_coef(4, t, 32'h7FF);
      set_len(5);
      run(45, 0, 3, 3, 0, 32'h800);
      check("R3 max positive", longint'(acc_out), 64'sd33554432);
      run(10, 0, 4, 4, 0, 32'h800);
      check("R3 most negative", longint'(acc_out), -64'sd33538048);
      run(10, 0, 3, 4, 0, 32'h7FF);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule